// File: doc/BRIEF.md
# Dual-Role Bridge Reset Sequencer

This block orders the reset intervals of a host-to-PCI bridge that can serve as the system's primary bridge or as a secondary one. It runs on the host bus clock. A power-good input gates the whole sequence. While power-good is low, every reset output is held active. The block also counts host clock edges from power-up, and power-good is accepted only after a minimum number of them. If power-good arrives earlier, a sticky error flag is raised.

When power-good is accepted, the bridge identifier on the strap pins is captured, and that value fixes the role. An identifier of zero makes the bridge primary. In that role it keeps driving host reset for a parameterised count of clocks, and drives the configuration-value word onto the host data bus during that time. A CPU-strap reset follows host reset and releases exactly two clocks after it. Any other identifier makes the bridge secondary. A secondary bridge stops driving host reset and follows the incoming host reset line for its internal default reset.

Both roles hold the PCI bus reset for the same parameterised count. All reset outputs are active-low and come from flops.

Top module: `brs_seq`

## Requirements
- R1: The identifier `id_q` takes the value of `strap_id` on the clock edge at which power-good is accepted. It keeps that value until power-good drops, whatever happens on `strap_id` or `host_rst_n_in` afterwards.
- R2: Until the role is resolved, the outputs hold this state: `host_rst_oe`=1, `host_rst_n_o`=0, `cpu_cfg_rst_n`=0, `pci_rst_n`=0, `hd_oe`=0 and `reg_dflt_rst_n`=0.
- R3: A captured identifier of zero selects the primary role and any other value selects the secondary role. `is_primary` is 1 only while resolved as primary.
- R4: On a primary bridge, `host_rst_n_o` rises exactly MS_CYCLES clock edges after the resolving edge. `host_rst_oe` stays 1 throughout.
- R5: On a primary bridge, `cpu_cfg_rst_n` rises exactly 2 clock edges after `host_rst_n_o` rises. On a secondary bridge, it rises at the resolving edge.
- R6: In both roles, `pci_rst_n` rises exactly MS_CYCLES clock edges after the resolving edge.
- R7: `hd_oe` is 1 exactly while a primary bridge holds host reset. `hd_out` equals `cfg_word` while `hd_oe` is 1 and is zero otherwise.
- R8: `reg_dflt_rst_n` is low while host reset is active. On a primary bridge this means its own driven reset. On a secondary bridge it follows `host_rst_n_in`, one clock edge later.
- R9: On a secondary bridge, `host_rst_oe` goes to 0 at the resolving edge and stays 0.
- R10: Power-good is accepted only on the first edge at which at least WARMUP clock edges have already occurred. If synchronised power-good is seen high before then, `pg_early_err` is set and stays set.
- R11: `pwr_good` passes through a two-flop synchroniser. The role resolves on the third clock edge after `pwr_good` rises, provided warm-up is complete. Dropping `pwr_good` at any time returns every output at once to the R2 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| pwr_good | input | 1 | Asynchronous power-good, high when supplies are good |
| strap_id | input | ID_W | Bridge identifier strap pins |
| host_rst_n_in | input | 1 | Sensed level of the host reset pin |
| cfg_word | input | DATA_W | Configuration-value word for the host data bus |
| host_rst_n_o | output | 1 | Value driven onto the host reset pin, active-low |
| host_rst_oe | output | 1 | Output enable of the host reset pin driver |
| cpu_cfg_rst_n | output | 1 | CPU-strap reset, active-low |
| pci_rst_n | output | 1 | PCI bus reset, active-low |
| hd_oe | output | 1 | Enable for driving the configuration word onto the host data bus |
| hd_out | output | DATA_W | Configuration word gated by hd_oe |
| reg_dflt_rst_n | output | 1 | Internal register-default reset, active-low |
| id_q | output | ID_W | Captured bridge identifier |
| is_primary | output | 1 | High while resolved as primary bridge |
| pg_early_err | output | 1 | Sticky flag: power-good seen before clock warm-up |

## Verification
The bench raises power-good before warm-up is complete. A design that accepts it early resolves before edge 11, and one that ignores the error leaves the flag low.

The bench also times each release to the exact edge. An off-by-one in the interval counter moves the host or PCI release by one edge. A trailing stage of the wrong length moves the CPU-strap release away from two edges after host reset.

The secondary pass toggles the incoming host reset line and changes the straps after resolution. A design that recaptures the identifier on that activity, or keeps driving the pin, shows up at the ports.

Power-good is also dropped in the middle of the hold interval and after a secondary run. A sequencer that does not restart cleanly, or that keeps a stale timer, releases at the wrong edge on the next pass.

// File: rtl/brs_pkg.sv
package brs_pkg;

   localparam int unsigned CPU_TRAIL = 2;

   typedef enum logic [2:0] {
      ST_WAIT     = 3'd0,
      ST_PRI_HOLD = 3'd1,
      ST_PRI_TAIL = 3'd2,
      ST_PRI_RUN  = 3'd3,
      ST_SEC_PCI  = 3'd4,
      ST_SEC_RUN  = 3'd5
   } seq_state_t;

   typedef struct packed {
      logic host_oe;
      logic host_n;
      logic cpu_n;
      logic pci_n;
      logic hd_oe;
   } rst_out_t;

   function automatic rst_out_t decode_state(seq_state_t s);
      rst_out_t o;
      case (s)
         ST_PRI_HOLD: o = '{host_oe: 1'b1, host_n: 1'b0, cpu_n: 1'b0, pci_n: 1'b0, hd_oe: 1'b1};
         ST_PRI_TAIL: o = '{host_oe: 1'b1, host_n: 1'b1, cpu_n: 1'b0, pci_n: 1'b1, hd_oe: 1'b0};
         ST_PRI_RUN:  o = '{host_oe: 1'b1, host_n: 1'b1, cpu_n: 1'b1, pci_n: 1'b1, hd_oe: 1'b0};
         ST_SEC_PCI:  o = '{host_oe: 1'b0, host_n: 1'b1, cpu_n: 1'b1, pci_n: 1'b0, hd_oe: 1'b0};
         ST_SEC_RUN:  o = '{host_oe: 1'b0, host_n: 1'b1, cpu_n: 1'b1, pci_n: 1'b1, hd_oe: 1'b0};
         default:     o = '{host_oe: 1'b1, host_n: 1'b0, cpu_n: 1'b0, pci_n: 1'b0, hd_oe: 1'b0};
      endcase
      return o;
   endfunction

   function automatic logic is_sec_state(seq_state_t s);
      return (s == ST_SEC_PCI) || (s == ST_SEC_RUN);
   endfunction

endpackage

// File: rtl/brs_pgood_sync.sv
module brs_pgood_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("brs_pgood_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge async_in) begin
      if (!async_in) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/brs_warmup.sv
module brs_warmup #(
   parameter int unsigned WARMUP = 10
) (
   input  logic clk,
   input  logic pg_sync,
   output logic warm_done,
   output logic early_err
);

   localparam int unsigned WW = $clog2(WARMUP + 1);

   generate
      if (WARMUP < 1) begin : g_bad_warmup
         $error("brs_warmup: WARMUP must be at least 1");
      end
   endgenerate

   logic [WW-1:0] edge_cnt_q = '0;
   logic          err_q      = 1'b0;

   assign warm_done = (edge_cnt_q == WW'(WARMUP));

   always_ff @(posedge clk) begin
      if (!warm_done) begin
         edge_cnt_q <= edge_cnt_q + 1'b1;
      end
      if (pg_sync && !warm_done) begin
         err_q <= 1'b1;
      end
   end

   assign early_err = err_q;

   a_r10_err_sticky: assert property (@(posedge clk) err_q |=> err_q)
      else $error("a_r10_err_sticky: early flag cleared");

endmodule

// File: rtl/brs_timer.sv
module brs_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   generate
      if (CW < 1) begin : g_bad_cw
         $error("brs_timer: CW must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   a_r4_timer_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("a_r4_timer_moves: interval counter stalled");

endmodule

// File: rtl/brs_seq.sv
module brs_seq
   import brs_pkg::*;
#(
   parameter int unsigned ID_W      = 3,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MS_CYCLES = 66000,
   parameter int unsigned WARMUP    = 10,
   parameter int unsigned SYNC_STG  = 2
) (
   input  logic              clk,
   input  logic              pwr_good,
   input  logic [ID_W-1:0]   strap_id,
   input  logic              host_rst_n_in,
   input  logic [DATA_W-1:0] cfg_word,
   output logic              host_rst_n_o,
   output logic              host_rst_oe,
   output logic              cpu_cfg_rst_n,
   output logic              pci_rst_n,
   output logic              hd_oe,
   output logic [DATA_W-1:0] hd_out,
   output logic              reg_dflt_rst_n,
   output logic [ID_W-1:0]   id_q,
   output logic              is_primary,
   output logic              pg_early_err
);

   localparam int unsigned CNT_W = $clog2(MS_CYCLES + 1);

   generate
      if (ID_W < 1) begin : g_bad_id
         $error("brs_seq: ID_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("brs_seq: DATA_W must be at least 1");
      end
      if (MS_CYCLES < CPU_TRAIL) begin : g_bad_ms
         $error("brs_seq: MS_CYCLES too small");
      end
   endgenerate

   logic pg_s;
   logic warm_done;

   brs_pgood_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk      (clk),
      .async_in (pwr_good),
      .sync_out (pg_s)
   );

   brs_warmup #(.WARMUP(WARMUP)) u_warm (
      .clk       (clk),
      .pg_sync   (pg_s),
      .warm_done (warm_done),
      .early_err (pg_early_err)
   );

   seq_state_t       state_q, state_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             capture;

   brs_timer #(.CW(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (pg_s),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = CNT_W'(MS_CYCLES - 1);
      capture  = 1'b0;
      case (state_q)
         ST_WAIT: begin
            if (warm_done) begin
               capture  = 1'b1;
               tmr_load = 1'b1;
               state_d  = (strap_id == '0) ? ST_PRI_HOLD : ST_SEC_PCI;
            end
         end
         ST_PRI_HOLD: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(CPU_TRAIL - 1);
               state_d  = ST_PRI_TAIL;
            end
         end
         ST_PRI_TAIL: begin
            if (tmr_exp) state_d = ST_PRI_RUN;
         end
         ST_SEC_PCI: begin
            if (tmr_exp) state_d = ST_SEC_RUN;
         end
         default: state_d = state_q;
      endcase
   end

   rst_out_t out_q, out_d;
   logic     dflt_q;

   assign out_d = decode_state(state_d);

   always_ff @(posedge clk or negedge pg_s) begin
      if (!pg_s) begin
         state_q <= ST_WAIT;
         id_q    <= '0;
         out_q   <= decode_state(ST_WAIT);
         dflt_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (capture) id_q <= strap_id;
         out_q   <= out_d;
         dflt_q  <= is_sec_state(state_d) ? host_rst_n_in : out_d.host_n;
      end
   end

   assign host_rst_oe    = out_q.host_oe;
   assign host_rst_n_o   = out_q.host_n;
   assign cpu_cfg_rst_n  = out_q.cpu_n;
   assign pci_rst_n      = out_q.pci_n;
   assign hd_oe          = out_q.hd_oe;
   assign hd_out         = out_q.hd_oe ? cfg_word : '0;
   assign reg_dflt_rst_n = dflt_q;
   assign is_primary     = (state_q != ST_WAIT) && !is_sec_state(state_q);

   a_r5_cpu_trail: assert property (@(posedge clk) disable iff (!pg_s)
      ($rose(host_rst_n_o) && host_rst_oe) |-> (!cpu_cfg_rst_n ##1 !cpu_cfg_rst_n ##1 cpu_cfg_rst_n))
      else $error("a_r5_cpu_trail: CPU-strap reset not two edges behind host reset");

   a_r1_id_hold: assert property (@(posedge clk) disable iff (!pg_s)
      (state_q != ST_WAIT) |=> $stable(id_q))
      else $error("a_r1_id_hold: identifier changed after capture");

   a_r10_no_early_accept: assert property (@(posedge clk) disable iff (!pg_s)
      (state_q == ST_WAIT && !warm_done) |=> (state_q == ST_WAIT))
      else $error("a_r10_no_early_accept: power-good accepted before warm-up");

   a_r7_hd_in_reset: assert property (@(posedge clk) disable iff (!pg_s)
      hd_oe |-> (host_rst_oe && !host_rst_n_o && !reg_dflt_rst_n))
      else $error("a_r7_hd_in_reset: data drivers enabled outside host reset");

   a_r9_sec_released: assert property (@(posedge clk) disable iff (!pg_s)
      (is_sec_state(state_q) && !host_rst_oe) |=> !host_rst_oe)
      else $error("a_r9_sec_released: secondary drives host reset again");

   a_r6_pci_after_host: assert property (@(posedge clk) disable iff (!pg_s)
      (host_rst_oe && !host_rst_n_o) |-> !pci_rst_n)
      else $error("a_r6_pci_after_host: PCI reset released during host reset");

endmodule

// File: tb/brs_seq_test.sv
module brs_seq_test;

   localparam int PER   = 10;
   localparam int ID_W  = 3;
   localparam int DW    = 16;
   localparam int MS    = 20;
   localparam int WARM  = 10;
   localparam logic [DW-1:0] CFG = 16'hA5C3;

   logic          clk = 1'b0;
   logic          pwr_good = 1'b1;
   logic [ID_W-1:0] strap_id = '0;
   logic          host_rst_n_in = 1'b0;
   logic [DW-1:0] cfg_word = CFG;
   logic          host_rst_n_o, host_rst_oe, cpu_cfg_rst_n, pci_rst_n, hd_oe;
   logic [DW-1:0] hd_out;
   logic          reg_dflt_rst_n, is_primary, pg_early_err;
   logic [ID_W-1:0] id_q;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   always #(PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   brs_seq #(.ID_W(ID_W), .DATA_W(DW), .MS_CYCLES(MS), .WARMUP(WARM), .SYNC_STG(2)) uut (
      .clk(clk), .pwr_good(pwr_good), .strap_id(strap_id), .host_rst_n_in(host_rst_n_in),
      .cfg_word(cfg_word), .host_rst_n_o(host_rst_n_o), .host_rst_oe(host_rst_oe),
      .cpu_cfg_rst_n(cpu_cfg_rst_n), .pci_rst_n(pci_rst_n), .hd_oe(hd_oe), .hd_out(hd_out),
      .reg_dflt_rst_n(reg_dflt_rst_n), .id_q(id_q), .is_primary(is_primary),
      .pg_early_err(pg_early_err)
   );

   // vector order: oe, host_n, cpu_n, pci_n, hd_oe, dflt_n
   function automatic logic [5:0] outv();
      return {host_rst_oe, host_rst_n_o, cpu_cfg_rst_n, pci_rst_n, hd_oe, reg_dflt_rst_n};
   endfunction

   typedef struct {
      int         at;
      logic [5:0] v;
      string      tag;
   } ev_t;

   ev_t exp_q[$];

   task automatic push_ev(input int at, input logic [5:0] v, input string tag);
      ev_t e;
      e.at = at; e.v = v; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, want, cyc);
      end
   endtask

   task automatic at_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // monitor: pops an expected item at every change of the reset outputs
   logic [5:0] prev_v;
   bit         have_prev = 0;
   initial begin
      forever begin
         @(posedge clk);
         #(PER/4);
         if (have_prev && outv() !== prev_v) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL unexpected change: got %b at cycle %0d expected no change", outv(), cyc);
            end else begin
               ev_t e;
               e = exp_q.pop_front();
               if (e.at != cyc || e.v !== outv()) begin
                  errors++;
                  $display("FAIL %s: got %b at cycle %0d expected %b at cycle %0d",
                           e.tag, outv(), cyc, e.v, e.at);
               end
            end
         end
         prev_v    = outv();
         have_prev = 1;
      end
   end

   initial begin
      #1 pwr_good = 1'b0;
      at_cyc(1);
      chk("R2 reset outputs", 32'(outv()), 32'(6'b100000));
      chk("R10 no early flag at reset", 32'(pg_early_err), 32'd0);
      chk("R3 not primary before resolve", 32'(is_primary), 32'd0);
      chk("R7 data bus idle at reset", 32'(hd_out), 32'd0);

      // primary pass, power-good arrives before warm-up
      at_cyc(2);
      pwr_good = 1'b1;
      push_ev(11, 6'b100010, "R10 R11 accept after warm-up");
      push_ev(31, 6'b110101, "R4 R6 host and pci release");
      push_ev(33, 6'b111101, "R5 cpu strap two edges later");
      at_cyc(4);
      chk("R10 flag low before sync", 32'(pg_early_err), 32'd0);
      at_cyc(6);
      chk("R10 early flag set", 32'(pg_early_err), 32'd1);
      at_cyc(12);
      chk("R3 primary for id 0", 32'(is_primary), 32'd1);
      chk("R1 id captured", 32'(id_q), 32'd0);
      chk("R7 config word driven", 32'(hd_out), 32'(CFG));
      at_cyc(35);
      chk("R7 config word released", 32'(hd_out), 32'd0);

      // drop, then secondary pass
      at_cyc(40);
      pwr_good = 1'b0;
      push_ev(41, 6'b100000, "R11 drop returns to reset");
      at_cyc(44);
      strap_id = 3'd5;
      host_rst_n_in = 1'b0;
      pwr_good = 1'b1;
      push_ev(47, 6'b011000, "R9 R5 secondary releases pin");
      push_ev(67, 6'b011100, "R6 secondary pci release");
      at_cyc(50);
      chk("R3 secondary for id 5", 32'(is_primary), 32'd0);
      chk("R1 id captured secondary", 32'(id_q), 32'd5);
      chk("R10 flag stays set", 32'(pg_early_err), 32'd1);
      at_cyc(70);
      host_rst_n_in = 1'b1;
      push_ev(71, 6'b011101, "R8 default reset follows input");
      at_cyc(75);
      host_rst_n_in = 1'b0;
      strap_id = 3'd2;
      push_ev(76, 6'b011100, "R8 default reset reasserted");
      at_cyc(78);
      chk("R1 id unchanged by host reset activity", 32'(id_q), 32'd5);
      at_cyc(80);
      host_rst_n_in = 1'b1;
      push_ev(81, 6'b011101, "R8 default reset released again");

      // drop, restart primary, abort mid-hold
      at_cyc(85);
      pwr_good = 1'b0;
      push_ev(86, 6'b100000, "R11 drop from secondary");
      at_cyc(90);
      strap_id = 3'd0;
      pwr_good = 1'b1;
      push_ev(93, 6'b100010, "R11 three edges to resolve");
      at_cyc(100);
      pwr_good = 1'b0;
      push_ev(101, 6'b100000, "R11 drop mid hold");
      at_cyc(102);
      chk("R2 hold aborted outputs", 32'(outv()), 32'(6'b100000));
      at_cyc(105);
      pwr_good = 1'b1;
      push_ev(108, 6'b100010, "R4 fresh hold");
      push_ev(128, 6'b110101, "R4 R6 fresh release");
      push_ev(130, 6'b111101, "R5 fresh cpu strap release");
      at_cyc(140);
      chk("R4 all expected transitions seen", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PER * 2000);
      checks++;
      errors++;
      $display("FAIL watchdog: got cycle %0d expected end by cycle 140", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule